// File: doc/BRIEF.md
# Crypto descriptor chain walker

This block runs ahead of a block-cipher datapath. It fetches a chain of six-word descriptors from memory and checks each header. It then turns the two buffers each descriptor names into a stream of address/length commands for the cipher datapath. A single-cycle `start` pulse carries the byte address of the first descriptor. Memory is read through a simple word-read port with a fixed latency of one cycle.

A header flag selects how the two buffer pointers are used. When the flag is set, each pointer addresses its buffer directly, for example an IV and a key. When it is clear, each pointer is the head of a linked list of three-word segment entries. The first list describes the input and the second describes the output. The walker follows next pointers until it reads a zero. It then raises `done`, or at the first violation it raises `err` with a 4-bit cause code. After either event it returns to idle.

Top module: `cdw_chain_walker`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `cmd_valid` are low, and `err_code` and `err_sub` are zero.
- R2: A descriptor is six words read from consecutive word addresses: header, length 1, pointer 1, length 2, pointer 2, next. A nonzero next word fetches another descriptor. When a descriptor's next word is zero and its buffers are finished, `done` pulses for one cycle with `err_code` = 0.
- R3: The header needs odd parity over all 32 bits, with bit 31 acting as the parity bit. The form in bits 19:16 must be 5 (data) or 8 (key), and the engine in bits 30:28 must be 1 (cipher) or 2 (hash). Any violation ends the walk with code 1.
- R4: With header bit 24 set, each buffer gives one command. Buffer 1 comes first with `cmd_sel` = 0, then buffer 2 with `cmd_sel` = 1. `cmd_flags` = {form is 8, header bit 3 (CBC), header bit 2 (encrypt)}.
- R5: If buffer 1 has length 0 and pointer 0, it is skipped. A buffer with exactly one of its length and pointer zero, or a buffer 2 with both zero, ends the walk with code 2.
- R6: With header bit 24 clear, each pointer heads a list of three-word entries: segment length, segment address, next entry. Each segment of nonzero length gives one command, in list order. List 1 comes first with `cmd_sel` = 0, then list 2 with `cmd_sel` = 1.
- R7: If the segment lengths of a list do not add up to its buffer length, the walk ends with code 4. It also ends with code 4 if a list would hold more than `MAX_LINKS` entries.
- R8: A segment entry whose address word is zero ends the walk with code 5.
- R9: A descriptor address that is not word aligned, either at start or in a next field, gives code 12. A link address that is not word aligned gives code 13.
- R10: If a buffer or segment would cross a 256-byte address boundary (low address byte plus length greater than 256), no command is issued and the walk ends with code 15 and `err_sub` = 4. `err_sub` is 0 for every other code.
- R11: An error pulses `err` for one cycle and returns the block to idle. `err_code` holds until the next accepted start. A `start` that arrives while `busy` is high is ignored.
- R12: Every memory read address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only while idle |
| start_addr | input | 32 | Byte address of the first descriptor |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Byte address of the word to read |
| mem_rd_data | input | 32 | Read data, one cycle after the request |
| cmd_valid | output | 1 | Command strobe for the cipher datapath |
| cmd_sel | output | 1 | 0 = buffer/list 1, 1 = buffer/list 2 |
| cmd_flags | output | 3 | {key form, CBC, encrypt} |
| cmd_addr | output | 32 | Command byte address |
| cmd_len | output | 32 | Command length in bytes |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse on clean completion |
| err | output | 1 | One-cycle pulse on abort |
| err_code | output | 4 | Cause code, held until the next start |
| err_sub | output | 3 | Sub-cause for code 15 |

## Verification
Two cases are hard to reach from the ports: aborting partway through a list after some commands have already been issued, and hitting the per-list entry limit. The bench builds chains in its word-array memory for these cases. For example, one list has nine short entries, so the limit trips after exactly seven commands. Another list has a length total that is wrong only at its last entry. The 256-byte boundary rule is swept over a grid of address offsets and lengths, and the expected cause code and command count for each point are computed arithmetically. A second start is injected during a long walk to show it has no effect on the result.

// File: rtl/cdw_pkg.sv
package cdw_pkg;

    localparam int DESC_WORDS = 6;
    localparam int LINK_WORDS = 3;
    localparam int PAGE_BITS  = 8;
    localparam int PAGE_BYTES = 1 << PAGE_BITS;

    localparam logic [3:0] FORM_DATA  = 4'd5;
    localparam logic [3:0] FORM_KEY   = 4'd8;
    localparam logic [2:0] ENG_CIPHER = 3'd1;
    localparam logic [2:0] ENG_HASH   = 3'd2;

    localparam int HB_ENC    = 2;
    localparam int HB_CBC    = 3;
    localparam int HB_DIRECT = 24;

    localparam logic [2:0] DMA_SUB_PAGE = 3'd4;

    typedef enum logic [3:0] {
        ERR_NONE  = 4'd0,
        ERR_HDR   = 4'd1,
        ERR_DLEN  = 4'd2,
        ERR_LLEN  = 4'd4,
        ERR_LPTR  = 4'd5,
        ERR_DADDR = 4'd12,
        ERR_LADDR = 4'd13,
        ERR_DMA   = 4'd15
    } err_e;

    typedef struct packed {
        logic [31:0] hdr;
        logic [31:0] len1;
        logic [31:0] ptr1;
        logic [31:0] len2;
        logic [31:0] ptr2;
        logic [31:0] next;
    } desc_t;

    typedef struct packed {
        logic [31:0] len;
        logic [31:0] addr;
        logic [31:0] next;
    } link_t;

    typedef enum logic [1:0] {BUF_SKIP, BUF_BAD, BUF_DIRECT, BUF_LIST} buf_act_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DWAIT, ST_DCHK, ST_BUF, ST_LADDR, ST_LWAIT, ST_LCHK, ST_NEXT
    } state_e;

    function automatic logic hdr_valid(input logic [31:0] h);
        logic form_ok;
        logic eng_ok;
        form_ok = (h[19:16] == FORM_DATA) || (h[19:16] == FORM_KEY);
        eng_ok  = (h[30:28] == ENG_CIPHER) || (h[30:28] == ENG_HASH);
        return (^h) && form_ok && eng_ok;
    endfunction

    function automatic logic crosses_page(input logic [PAGE_BITS-1:0] offs,
                                          input logic [31:0] len);
        logic [32:0] span;
        span = {{(33-PAGE_BITS){1'b0}}, offs} + {1'b0, len};
        return span > 33'(PAGE_BYTES);
    endfunction

endpackage

// File: rtl/cdw_fetch.sv
module cdw_fetch #(
    parameter int DW   = 32,
    parameter int MAXW = 6,
    localparam int IW  = $clog2(MAXW + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     go,
    input  logic [DW-1:0]            base,
    input  logic [IW-1:0]            count,
    output logic                     rd_en,
    output logic [DW-1:0]            rd_addr,
    input  logic [DW-1:0]            rd_data,
    output logic [MAXW-1:0][DW-1:0]  words,
    output logic                     done
);

    logic          active;
    logic [IW-1:0] issue_idx;
    logic [IW-1:0] cnt_r;
    logic          pend;
    logic [IW-1:0] pend_idx;
    logic [DW-1:0] base_r;

    assign rd_en   = active && (issue_idx < cnt_r);
    assign rd_addr = base_r + DW'({issue_idx, 2'b00});

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            issue_idx <= '0;
            cnt_r     <= '0;
            pend      <= 1'b0;
            pend_idx  <= '0;
            base_r    <= '0;
            words     <= '0;
            done      <= 1'b0;
        end else begin
            done     <= 1'b0;
            pend     <= rd_en;
            pend_idx <= issue_idx;
            if (go) begin
                active    <= 1'b1;
                issue_idx <= '0;
                cnt_r     <= count;
                base_r    <= base;
            end else if (rd_en) begin
                issue_idx <= issue_idx + IW'(1);
            end
            if (pend) begin
                words[pend_idx] <= rd_data;
                if (pend_idx == cnt_r - IW'(1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cdw_buf_class.sv
module cdw_buf_class
    import cdw_pkg::*;
(
    input  logic [31:0] len,
    input  logic [31:0] ptr,
    input  logic        first,
    input  logic        direct,
    output buf_act_e    act
);

    always_comb begin
        if (len == '0 && ptr == '0)
            act = first ? BUF_SKIP : BUF_BAD;
        else if (len == '0 || ptr == '0)
            act = BUF_BAD;
        else
            act = direct ? BUF_DIRECT : BUF_LIST;
    end

endmodule

// File: rtl/cdw_chain_walker.sv
module cdw_chain_walker
    import cdw_pkg::*;
#(
    parameter int MAX_LINKS = 8,
    localparam int LCW = $clog2(MAX_LINKS + 1),
    localparam int FIW = $clog2(DESC_WORDS + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] start_addr,
    output logic        mem_rd_en,
    output logic [31:0] mem_rd_addr,
    input  logic [31:0] mem_rd_data,
    output logic        cmd_valid,
    output logic        cmd_sel,
    output logic [2:0]  cmd_flags,
    output logic [31:0] cmd_addr,
    output logic [31:0] cmd_len,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [3:0]  err_code,
    output logic [2:0]  err_sub
);

    state_e                        state;
    desc_t                         desc;
    logic                          sel;
    logic [31:0]                   link_addr;
    logic [31:0]                   sum;
    logic [LCW-1:0]                lcnt;
    logic                          f_go;
    logic [31:0]                   f_base;
    logic [FIW-1:0]                f_count;
    logic [DESC_WORDS-1:0][31:0]   f_words;
    logic                          f_done;
    link_t                         lk;
    buf_act_e                      act;
    logic [31:0]                   cur_len;
    logic [31:0]                   cur_ptr;
    logic                          fail;
    err_e                          fail_code;
    logic                          emit;
    logic [31:0]                   e_addr;
    logic [31:0]                   e_len;

    cdw_fetch #(.DW(32), .MAXW(DESC_WORDS)) u_fetch (
        .clk(clk), .rst(rst), .go(f_go), .base(f_base), .count(f_count),
        .rd_en(mem_rd_en), .rd_addr(mem_rd_addr), .rd_data(mem_rd_data),
        .words(f_words), .done(f_done)
    );

    assign cur_len = sel ? desc.len2 : desc.len1;
    assign cur_ptr = sel ? desc.ptr2 : desc.ptr1;

    cdw_buf_class u_class (
        .len(cur_len), .ptr(cur_ptr), .first(!sel),
        .direct(desc.hdr[HB_DIRECT]), .act(act)
    );

    assign lk.len  = f_words[0];
    assign lk.addr = f_words[1];
    assign lk.next = f_words[2];

    always_comb begin
        fail      = 1'b0;
        fail_code = ERR_NONE;
        emit      = 1'b0;
        e_addr    = cur_ptr;
        e_len     = cur_len;
        case (state)
            ST_IDLE: if (start && start_addr[1:0] != 2'b00) begin
                fail = 1'b1; fail_code = ERR_DADDR;
            end
            ST_DCHK: if (!hdr_valid(desc.hdr)) begin
                fail = 1'b1; fail_code = ERR_HDR;
            end
            ST_BUF: begin
                if (act == BUF_BAD) begin
                    fail = 1'b1; fail_code = ERR_DLEN;
                end else if (act == BUF_DIRECT) begin
                    if (crosses_page(cur_ptr[PAGE_BITS-1:0], cur_len)) begin
                        fail = 1'b1; fail_code = ERR_DMA;
                    end else begin
                        emit = 1'b1;
                    end
                end
            end
            ST_LADDR: if (link_addr[1:0] != 2'b00) begin
                fail = 1'b1; fail_code = ERR_LADDR;
            end
            ST_LCHK: begin
                e_addr = lk.addr;
                e_len  = lk.len;
                if (lk.addr == '0) begin
                    fail = 1'b1; fail_code = ERR_LPTR;
                end else if (crosses_page(lk.addr[PAGE_BITS-1:0], lk.len)) begin
                    fail = 1'b1; fail_code = ERR_DMA;
                end else if (lk.next == '0 && (sum + lk.len) != cur_len) begin
                    fail = 1'b1; fail_code = ERR_LLEN;
                end else if (lk.next != '0 && lcnt == LCW'(MAX_LINKS - 1)) begin
                    fail = 1'b1; fail_code = ERR_LLEN;
                end else begin
                    emit = (lk.len != '0);
                end
            end
            ST_NEXT: if (desc.next != '0 && desc.next[1:0] != 2'b00) begin
                fail = 1'b1; fail_code = ERR_DADDR;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            desc      <= '0;
            sel       <= 1'b0;
            link_addr <= '0;
            sum       <= '0;
            lcnt      <= '0;
            f_go      <= 1'b0;
            f_base    <= '0;
            f_count   <= '0;
            cmd_valid <= 1'b0;
            cmd_sel   <= 1'b0;
            cmd_flags <= '0;
            cmd_addr  <= '0;
            cmd_len   <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
            err_code  <= '0;
            err_sub   <= '0;
        end else begin
            done      <= 1'b0;
            err       <= 1'b0;
            f_go      <= 1'b0;
            cmd_valid <= emit;
            if (emit) begin
                cmd_sel   <= sel;
                cmd_flags <= {desc.hdr[19:16] == FORM_KEY, desc.hdr[HB_CBC], desc.hdr[HB_ENC]};
                cmd_addr  <= e_addr;
                cmd_len   <= e_len;
            end
            if (fail) begin
                err      <= 1'b1;
                err_code <= fail_code;
                err_sub  <= (fail_code == ERR_DMA) ? DMA_SUB_PAGE : 3'd0;
                busy     <= 1'b0;
                state    <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: if (start) begin
                        busy     <= 1'b1;
                        err_code <= '0;
                        err_sub  <= '0;
                        f_go     <= 1'b1;
                        f_base   <= start_addr;
                        f_count  <= FIW'(DESC_WORDS);
                        state    <= ST_DWAIT;
                    end
                    ST_DWAIT: if (f_done) begin
                        desc  <= {f_words[0], f_words[1], f_words[2],
                                  f_words[3], f_words[4], f_words[5]};
                        state <= ST_DCHK;
                    end
                    ST_DCHK: begin
                        sel   <= 1'b0;
                        state <= ST_BUF;
                    end
                    ST_BUF: begin
                        if (act == BUF_LIST) begin
                            link_addr <= cur_ptr;
                            sum       <= '0;
                            lcnt      <= '0;
                            state     <= ST_LADDR;
                        end else if (!sel) begin
                            sel <= 1'b1;
                        end else begin
                            state <= ST_NEXT;
                        end
                    end
                    ST_LADDR: begin
                        f_go    <= 1'b1;
                        f_base  <= link_addr;
                        f_count <= FIW'(LINK_WORDS);
                        state   <= ST_LWAIT;
                    end
                    ST_LWAIT: if (f_done) state <= ST_LCHK;
                    ST_LCHK: begin
                        sum  <= sum + lk.len;
                        lcnt <= lcnt + LCW'(1);
                        if (lk.next != '0) begin
                            link_addr <= lk.next;
                            state     <= ST_LADDR;
                        end else if (!sel) begin
                            sel   <= 1'b1;
                            state <= ST_BUF;
                        end else begin
                            state <= ST_NEXT;
                        end
                    end
                    ST_NEXT: begin
                        if (desc.next == '0) begin
                            done  <= 1'b1;
                            busy  <= 1'b0;
                            state <= ST_IDLE;
                        end else begin
                            f_go    <= 1'b1;
                            f_base  <= desc.next;
                            f_count <= FIW'(DESC_WORDS);
                            state   <= ST_DWAIT;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/cdw_chain_walker_chk.sv
module cdw_chain_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        rd_en,
    input logic [1:0]  rd_addr_lo,
    input logic        cmd_valid,
    input logic [7:0]  cmd_addr_lo,
    input logic [31:0] cmd_len,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic [3:0]  err_code,
    input logic [2:0]  err_sub
);

    assert_end_excl_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, err}));

    assert_done_clean_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> (err_code == 4'd0 && !busy));

    assert_err_idle_R11: assert property (@(posedge clk) disable iff (rst)
        err |-> (err_code != 4'd0 && !busy));

    assert_code_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(err_code));

    assert_busy_from_start_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_cmd_in_walk_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> busy);

    assert_no_page_cross_R10: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (({25'd0, cmd_addr_lo} + {1'b0, cmd_len}) <= 33'd256));

    assert_dma_sub_R10: assert property (@(posedge clk) disable iff (rst)
        (err && err_code == 4'd15) |-> err_sub == 3'd4);

    assert_read_align_R12: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> rd_addr_lo == 2'b00);

endmodule

bind cdw_chain_walker cdw_chain_walker_chk u_chk (
    .clk(clk), .rst(rst), .start(start),
    .rd_en(mem_rd_en), .rd_addr_lo(mem_rd_addr[1:0]),
    .cmd_valid(cmd_valid), .cmd_addr_lo(cmd_addr[7:0]), .cmd_len(cmd_len),
    .busy(busy), .done(done), .err(err), .err_code(err_code), .err_sub(err_sub)
);

// File: tb/cdw_chain_walker_bench.sv
`timescale 1ns/1ps
module cdw_chain_walker_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        cmd_valid;
    logic        cmd_sel;
    logic [2:0]  cmd_flags;
    logic [31:0] cmd_addr;
    logic [31:0] cmd_len;
    logic        busy;
    logic        done;
    logic        err;
    logic [3:0]  err_code;
    logic [2:0]  err_sub;

    always #10 clk = ~clk;

    cdw_chain_walker u_cdw_chain_walker (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .cmd_valid(cmd_valid), .cmd_sel(cmd_sel), .cmd_flags(cmd_flags),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .busy(busy), .done(done),
        .err(err), .err_code(err_code), .err_sub(err_sub)
    );

    logic [31:0] mem [0:1023];
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[11:2]];

    logic [3:0]  log_sf   [0:255];
    logic [31:0] log_addr [0:255];
    logic [31:0] log_len  [0:255];
    int lograw = 0;
    int badrd = 0;
    always @(negedge clk) begin
        if (mem_rd_en && mem_rd_addr[1:0] != 2'b00) badrd++;
        if (cmd_valid) begin
            log_sf[lograw % 256]   = {cmd_sel, cmd_flags};
            log_addr[lograw % 256] = cmd_addr;
            log_len[lograw % 256]  = cmd_len;
            lograw++;
        end
    end

    logic [3:0]  exp_sf   [0:63];
    logic [31:0] exp_addr [0:63];
    logic [31:0] exp_len  [0:63];
    int expn = 0;
    int base = 0;
    int nchk = 0;
    int nerr = 0;
    logic       got_done, got_err;
    logic [3:0] got_code;
    logic [2:0] got_sub;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkhdr(input logic [3:0] form, input logic [2:0] eng,
                                          input logic direct, input logic enc, input logic cbc);
        logic [31:0] h;
        h = '0;
        h[19:16] = form;
        h[30:28] = eng;
        h[24] = direct;
        h[2] = enc;
        h[3] = cbc;
        if (^h == 1'b0) h[31] = 1'b1;
        return h;
    endfunction

    task automatic put_desc(input logic [31:0] a, input logic [31:0] h, l1, p1, l2, p2, nx);
        mem[(a >> 2) + 0] = h;
        mem[(a >> 2) + 1] = l1;
        mem[(a >> 2) + 2] = p1;
        mem[(a >> 2) + 3] = l2;
        mem[(a >> 2) + 4] = p2;
        mem[(a >> 2) + 5] = nx;
    endtask

    task automatic put_link(input logic [31:0] a, input logic [31:0] l, ad, nx);
        mem[(a >> 2) + 0] = l;
        mem[(a >> 2) + 1] = ad;
        mem[(a >> 2) + 2] = nx;
    endtask

    task automatic exp_cmd(input logic s, input logic [2:0] fl, input logic [31:0] a, input logic [31:0] l);
        exp_sf[expn] = {s, fl};
        exp_addr[expn] = a;
        exp_len[expn] = l;
        expn++;
    endtask

    task automatic run(input logic [31:0] a, input bit poke);
        got_done = 0; got_err = 0; got_code = 0; got_sub = 0;
        @(negedge clk);
        base = lograw;
        start = 1'b1;
        start_addr = a;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if (poke && i == 3) begin
                start = 1'b1;
                start_addr = 32'h103;
            end else begin
                start = 1'b0;
            end
            if (done || err) begin
                got_done = done; got_err = err; got_code = err_code; got_sub = err_sub;
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
        if (!got_done && !got_err) check("R2 walk finished", 32'd0, 32'd1);
        @(negedge clk);
    endtask

    task automatic verify(input string req, input logic [3:0] code);
        check({req, " end kind"}, {30'd0, got_done, got_err}, (code == 4'd0) ? 32'd2 : 32'd1);
        check({req, " err_code"}, 32'(got_code), 32'(code));
        check({req, " err_sub (R10)"}, 32'(got_sub), (code == 4'd15) ? 32'd4 : 32'd0);
        check({req, " cmd count"}, 32'(lograw - base), 32'(expn));
        for (int i = 0; i < expn; i++) begin
            if (i < lograw - base) begin
                check({req, " cmd sel/flags"}, 32'(log_sf[(base + i) % 256]), 32'(exp_sf[i]));
                check({req, " cmd addr"}, log_addr[(base + i) % 256], exp_addr[i]);
                check({req, " cmd len"}, log_len[(base + i) % 256], exp_len[i]);
            end
        end
    endtask

    task automatic build_chain();
        put_desc(32'h100, mkhdr(4'd8, 3'd1, 1'b1, 1'b1, 1'b1), 32'd16, 32'h9000_0010,
                 32'd16, 32'h9000_0100, 32'h140);
        put_desc(32'h140, mkhdr(4'd5, 3'd1, 1'b0, 1'b1, 1'b0), 32'd48, 32'h200,
                 32'd48, 32'h218, 32'h0);
        put_link(32'h200, 32'd16, 32'hB000_0000, 32'h20C);
        put_link(32'h20C, 32'd32, 32'hB000_0100, 32'h0);
        put_link(32'h218, 32'd48, 32'hC000_0080, 32'h0);
        expn = 0;
        exp_cmd(1'b0, 3'b111, 32'h9000_0010, 32'd16);
        exp_cmd(1'b1, 3'b111, 32'h9000_0100, 32'd16);
        exp_cmd(1'b0, 3'b001, 32'hB000_0000, 32'd16);
        exp_cmd(1'b0, 3'b001, 32'hB000_0100, 32'd32);
        exp_cmd(1'b1, 3'b001, 32'hC000_0080, 32'd48);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL R2 watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done/err", {30'd0, done, err}, 32'd0);
        check("R1 cmd_valid", 32'(cmd_valid), 32'd0);
        check("R1 err_code/sub", {25'd0, err_code, err_sub}, 32'd0);

        // R4 direct key descriptor, two buffers
        put_desc(32'h100, mkhdr(4'd8, 3'd1, 1'b1, 1'b1, 1'b1), 32'd16, 32'h9000_0010,
                 32'd16, 32'h9000_0100, 32'h0);
        expn = 0;
        exp_cmd(1'b0, 3'b111, 32'h9000_0010, 32'd16);
        exp_cmd(1'b1, 3'b111, 32'h9000_0100, 32'd16);
        run(32'h100, 0);
        verify("R4 direct", 4'd0);

        // R5 buffer 1 skipped, R4 flags sweep
        for (int m = 0; m < 4; m++) begin
            put_desc(32'h100, mkhdr(4'd5, 3'd2, 1'b1, m[0], m[1]), 32'd0, 32'd0,
                     32'd32, 32'hA000_0040, 32'h0);
            expn = 0;
            exp_cmd(1'b1, {1'b0, m[1], m[0]}, 32'hA000_0040, 32'd32);
            run(32'h100, 0);
            verify("R5 skip buffer 1 / R4 flags", 4'd0);
        end

        // R2 + R6 chain of two descriptors, second one linked
        build_chain();
        run(32'h100, 0);
        verify("R2 R6 chain", 4'd0);

        // R3 header checks
        mem[32'h100 >> 2] = mkhdr(4'd8, 3'd1, 1'b1, 1'b0, 1'b0) ^ 32'h8000_0000;
        mem[(32'h100 >> 2) + 5] = 32'h0;
        expn = 0;
        run(32'h100, 0);
        verify("R3 parity", 4'd1);
        mem[32'h100 >> 2] = mkhdr(4'd3, 3'd1, 1'b1, 1'b0, 1'b0);
        run(32'h100, 0);
        verify("R3 form", 4'd1);
        mem[32'h100 >> 2] = mkhdr(4'd5, 3'd3, 1'b1, 1'b0, 1'b0);
        run(32'h100, 0);
        verify("R3 engine", 4'd1);

        // R11 code held while idle
        repeat (20) @(negedge clk);
        check("R11 code held", 32'(err_code), 32'd1);
        check("R11 idle after error", 32'(busy), 32'd0);

        // R5 descriptor length errors
        put_desc(32'h100, mkhdr(4'd8, 3'd1, 1'b1, 1'b0, 1'b0), 32'd16, 32'h9000_0010,
                 32'd0, 32'd0, 32'h0);
        expn = 0;
        exp_cmd(1'b0, 3'b100, 32'h9000_0010, 32'd16);
        run(32'h100, 0);
        verify("R5 buffer 2 empty", 4'd2);
        put_desc(32'h100, mkhdr(4'd8, 3'd1, 1'b1, 1'b0, 1'b0), 32'd16, 32'd0,
                 32'd16, 32'h9000_0100, 32'h0);
        expn = 0;
        run(32'h100, 0);
        verify("R5 pointer zero", 4'd2);

        // R7 sum mismatch: 16 + 32 against 40
        put_desc(32'h100, mkhdr(4'd5, 3'd1, 1'b0, 1'b0, 1'b0), 32'd40, 32'h200,
                 32'd48, 32'h218, 32'h0);
        put_link(32'h200, 32'd16, 32'hB000_0000, 32'h20C);
        put_link(32'h20C, 32'd32, 32'hB000_0100, 32'h0);
        expn = 0;
        exp_cmd(1'b0, 3'b000, 32'hB000_0000, 32'd16);
        run(32'h100, 0);
        verify("R7 sum mismatch", 4'd4);

        // R7 nine entries against a limit of eight: seven commands go out
        for (int k = 0; k < 9; k++)
            put_link(32'h300 + 32'(12 * k), 32'd4, 32'hB000_0000 + 32'(16 * k),
                     (k == 8) ? 32'h0 : 32'h300 + 32'(12 * (k + 1)));
        put_desc(32'h100, mkhdr(4'd5, 3'd1, 1'b0, 1'b0, 1'b0), 32'd36, 32'h300,
                 32'd48, 32'h218, 32'h0);
        expn = 0;
        for (int k = 0; k < 7; k++) exp_cmd(1'b0, 3'b000, 32'hB000_0000 + 32'(16 * k), 32'd4);
        run(32'h100, 0);
        verify("R7 too many links", 4'd4);

        // R8 segment address zero
        put_link(32'h200, 32'd16, 32'h0, 32'h0);
        put_desc(32'h100, mkhdr(4'd5, 3'd1, 1'b0, 1'b0, 1'b0), 32'd16, 32'h200,
                 32'd48, 32'h218, 32'h0);
        expn = 0;
        run(32'h100, 0);
        verify("R8 link pointer", 4'd5);

        // R9 alignment errors
        expn = 0;
        run(32'h102, 0);
        verify("R9 start misaligned", 4'd12);
        put_desc(32'h100, mkhdr(4'd8, 3'd1, 1'b1, 1'b0, 1'b0), 32'd16, 32'h9000_0010,
                 32'd16, 32'h9000_0100, 32'h142);
        expn = 0;
        exp_cmd(1'b0, 3'b100, 32'h9000_0010, 32'd16);
        exp_cmd(1'b1, 3'b100, 32'h9000_0100, 32'd16);
        run(32'h100, 0);
        verify("R9 next misaligned", 4'd12);
        put_desc(32'h100, mkhdr(4'd5, 3'd1, 1'b0, 1'b0, 1'b0), 32'd16, 32'h202,
                 32'd48, 32'h218, 32'h0);
        expn = 0;
        run(32'h100, 0);
        verify("R9 link misaligned", 4'd13);

        // R10 page-boundary sweep on a direct buffer
        for (int oi = 0; oi < 5; oi++) begin
            for (int li = 0; li < 4; li++) begin
                int off;
                int len;
                off = (oi == 0) ? 0 : (oi == 1) ? 16 : (oi == 2) ? 128 : (oi == 3) ? 240 : 252;
                len = (li == 0) ? 4 : (li == 1) ? 16 : (li == 2) ? 128 : 256;
                put_desc(32'h100, mkhdr(4'd5, 3'd1, 1'b1, 1'b1, 1'b0), 32'(len),
                         32'hD000_0000 + 32'(off), 32'd4, 32'hE000_0000, 32'h0);
                expn = 0;
                if (off + len <= 256) begin
                    exp_cmd(1'b0, 3'b001, 32'hD000_0000 + 32'(off), 32'(len));
                    exp_cmd(1'b1, 3'b001, 32'hE000_0000, 32'd4);
                end
                run(32'h100, 0);
                verify("R10 sweep", (off + len <= 256) ? 4'd0 : 4'd15);
            end
        end

        // R10 segment crossing in a list
        put_link(32'h200, 32'd8, 32'hB000_00FC, 32'h0);
        put_desc(32'h100, mkhdr(4'd5, 3'd1, 1'b0, 1'b0, 1'b0), 32'd8, 32'h200,
                 32'd48, 32'h218, 32'h0);
        expn = 0;
        run(32'h100, 0);
        verify("R10 segment cross", 4'd15);

        // R11 start during a walk is ignored; clean restart clears code
        build_chain();
        run(32'h100, 1);
        verify("R11 start while busy", 4'd0);

        check("R12 aligned reads", 32'(badrd), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule